// File: doc/BRIEF.md
# Programmable Almost-Full / Almost-Empty Flag Logic

This block produces the two threshold flags of a dual-clock FIFO. The almost-full flag lives in the write-clock domain and compares the free-space count against an almost-full offset. The almost-empty flag lives in the read-clock domain and compares the stored-word count against an almost-empty offset. The FIFO storage and its pointer synchronisers sit outside the block. The block only receives the free-space count, already valid in the write domain, and the word count, already valid in the read domain.

Both offsets sit in write-domain registers. When master reset is asserted, a 3-bit select chooses one of three ways to fill them. The first is one of five fixed presets. The second is parallel loading, two words on a load strobe. The third is serial loading, one bit per write clock while a serial enable is high. A completion bit moves into the read domain through a two-stage synchroniser. Until programming completes, both flags use an offset of 8. Partial reset forces both flags to their idle state and leaves the offsets and the programming state unchanged. Master reset reconfigures everything.

Top module: `prog_almost_flags`

## Requirements
- R1: While master reset is low, select values 0, 1, 2, 3 and 4 load both offsets with 8, 16, 64, 256 and 1024 respectively. These offsets apply immediately after reset.
- R2: At each write-clock edge, af_n is loaded with 0 when the free-space count is less than or equal to the active almost-full offset, and with 1 otherwise.
- R3: At each read-clock edge, ae_n is loaded with 0 when the word count is less than or equal to the active almost-empty offset, and with 1 otherwise.
- R4: Select value 5 chooses parallel loading. The first write-clock edge with ld_en high stores ld_data as the almost-empty offset. The second such edge stores the almost-full offset and completes programming. Later strobes have no effect.
- R5: Select values 6 and 7 choose serial loading. On each write-clock edge with ser_en high, ser_din is shifted in, most significant bit first. The almost-empty offset comes first (PW bits), then the almost-full offset (PW bits). Programming completes on the 2*PW-th bit. ser_din is ignored while ser_en is low, and any bits after completion are ignored.
- R6: In the programmable modes, both flags use an offset of 8 until programming completes. This includes the interval after the first parallel word has been stored.
- R7: While prst_n is low, af_n is held at 1 and ae_n at 0. The offsets survive partial reset.
- R8: While mrst_n is low, af_n is 1 and ae_n is 0. Each master reset selects a new configuration from the select value.
- R9: The loading interface that the current mode does not use is ignored. ld_en has no effect in the serial and preset modes, and ser_en has no effect in the parallel and preset modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous |
| prst_n | input | 1 | Partial reset, active low, sampled in each domain |
| cfg_sel | input | 3 | Offset source select, captured while mrst_n is low |
| space_w | input | PW+1 | Free locations, write domain |
| words_r | input | PW+1 | Stored words, read domain |
| ld_en | input | 1 | Parallel load strobe (write domain) |
| ld_data | input | PW | Parallel offset value |
| ser_en | input | 1 | Serial shift enable (write domain) |
| ser_din | input | 1 | Serial offset bit |
| af_n | output | 1 | Almost-full flag, active low, write domain |
| ae_n | output | 1 | Almost-empty flag, active low, read domain |

## Verification
Programming and flag evaluation can fall on the same write-clock edge. On the edge that completes programming, the almost-full compare must still use the default offset. Interface strobes from the unused loading method can also coincide with valid loading edges. The bench provokes both by checking flags at the default boundary values 8 and 9 midway through a serial or parallel load. It also interleaves idle gaps carrying random serial bits and parallel strobes. The bench then checks both flags at each programmed offset and one above it. A lost, reordered or extra bit shows up as a flag that moves at the wrong count.

// File: rtl/prog_almost_flags.sv
module prog_almost_flags #(
  parameter int PW = 12,
  parameter int CW = PW + 1
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic [2:0]    cfg_sel,
  input  logic [CW-1:0] space_w,
  input  logic [CW-1:0] words_r,
  input  logic          ld_en,
  input  logic [PW-1:0] ld_data,
  input  logic          ser_en,
  input  logic          ser_din,
  output logic          af_n,
  output logic          ae_n
);
  localparam int SRW = 2 * PW - 1;
  localparam int BCW = $clog2(2 * PW + 1);
  localparam logic [BCW-1:0] LASTBIT = BCW'(2 * PW - 1);
  localparam logic [PW-1:0] DEF = PW'(8);

  function automatic logic [PW-1:0] preset(input logic [2:0] s);
    case (s)
      3'd1:    return PW'(16);
      3'd2:    return PW'(64);
      3'd3:    return PW'(256);
      3'd4:    return PW'(1024);
      default: return DEF;
    endcase
  endfunction

  logic [2:0]     mode;
  logic           done_w, phase;
  logic [PW-1:0]  ae_off, af_off;
  logic [SRW-1:0] sr;
  logic [BCW-1:0] bitcnt;
  logic           done_s1, done_s2;

  wire par_mode = (mode == 3'd5);
  wire ser_mode = (mode[2:1] == 2'b11);
  wire [PW-1:0] af_eff = done_w  ? af_off : DEF;
  wire [PW-1:0] ae_eff = done_s2 ? ae_off : DEF;

  always_ff @(posedge wclk or negedge mrst_n) begin
    if (!mrst_n) begin
      mode   <= cfg_sel;
      ae_off <= preset(cfg_sel);
      af_off <= preset(cfg_sel);
      done_w <= (cfg_sel < 3'd5);
      phase  <= 1'b0;
      bitcnt <= '0;
      sr     <= '0;
    end else if (!done_w) begin
      if (par_mode && ld_en) begin
        if (!phase) begin
          ae_off <= ld_data;
          phase  <= 1'b1;
        end else begin
          af_off <= ld_data;
          done_w <= 1'b1;
        end
      end else if (ser_mode && ser_en) begin
        sr     <= {sr[SRW-2:0], ser_din};
        bitcnt <= bitcnt + 1'b1;
        if (bitcnt == LASTBIT) begin
          ae_off <= sr[SRW-1:PW-1];
          af_off <= {sr[PW-2:0], ser_din};
          done_w <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge wclk or negedge mrst_n) begin
    if (!mrst_n)      af_n <= 1'b1;
    else if (!prst_n) af_n <= 1'b1;
    else              af_n <= !(space_w <= {1'b0, af_eff});
  end

  always_ff @(posedge rclk or negedge mrst_n) begin
    if (!mrst_n) {done_s2, done_s1} <= 2'b00;
    else         {done_s2, done_s1} <= {done_s1, done_w};
  end

  always_ff @(posedge rclk or negedge mrst_n) begin
    if (!mrst_n)      ae_n <= 1'b0;
    else if (!prst_n) ae_n <= 1'b0;
    else              ae_n <= !(words_r <= {1'b0, ae_eff});
  end

  // R2
  af_zero_space_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
    (space_w == '0 && prst_n) |=> !af_n);
  // R3
  ae_zero_words_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
    (words_r == '0 && prst_n) |=> !ae_n);
  // R7
  af_prst_idle_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
    !prst_n |=> af_n);
  // R7
  ae_prst_idle_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
    !prst_n |=> !ae_n);
  // R4
  done_sticky_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
    done_w |=> (done_w && $stable(ae_off) && $stable(af_off)));
  // R6
  ae_handoff_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
    done_s2 |-> done_w);
endmodule

// File: tb/tb_prog_almost_flags.sv
module tb_prog_almost_flags;
  localparam int PW = 12;
  localparam int CW = PW + 1;
  localparam int WPER = 10;
  localparam int RPER = 14;

  logic wclk = 0, rclk = 0, mrst_n = 0, prst_n = 1;
  logic [2:0] cfg_sel = 0;
  logic [CW-1:0] space_w = 0, words_r = 0;
  logic ld_en = 0, ser_en = 0, ser_din = 0;
  logic [PW-1:0] ld_data = 0;
  logic af_n, ae_n;
  int nchk = 0, nfail = 0;
  bit ended = 0;

  prog_almost_flags #(.PW(PW), .CW(CW)) dut (.*);

  always #(WPER/2) wclk = ~wclk;
  always #(RPER/2) rclk = ~rclk;

  function automatic bit exp_flag(input int cnt, input int off);
    return cnt > off;
  endfunction

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  task automatic chk_af(input int v, input int off, input string rq);
    @(negedge wclk) space_w = CW'(v);
    @(posedge wclk); @(negedge wclk);
    nchk++;
    if (af_n !== exp_flag(v, off)) begin
      nfail++;
      $display("FAIL %s af_n space=%0d act=%b exp=%b", rq, v, af_n, exp_flag(v, off));
    end
  endtask

  task automatic chk_ae(input int v, input int off, input string rq);
    @(negedge rclk) words_r = CW'(v);
    @(posedge rclk); @(negedge rclk);
    nchk++;
    if (ae_n !== exp_flag(v, off)) begin
      nfail++;
      $display("FAIL %s ae_n words=%0d act=%b exp=%b", rq, v, ae_n, exp_flag(v, off));
    end
  endtask

  task automatic sweep(input int aeo, input int afo, input string rq, input int n);
    chk_af(afo, afo, rq); chk_af(afo + 1, afo, rq); chk_af(0, afo, rq);
    chk_ae(aeo, aeo, rq); chk_ae(aeo + 1, aeo, rq); chk_ae(0, aeo, rq);
    for (int i = 0; i < n; i++) begin
      chk_af(int'($urandom % (1 << CW)), afo, rq);
      chk_ae(int'($urandom % (1 << CW)), aeo, rq);
    end
  endtask

  task automatic master_reset(input logic [2:0] s);
    @(negedge wclk) begin mrst_n = 0; cfg_sel = s; space_w = 0; words_r = 200; end
    repeat (3) @(posedge wclk);
    @(negedge wclk);
    nchk++;
    if (af_n !== 1'b1 || ae_n !== 1'b0) begin
      nfail++;
      $display("FAIL R8 reset flags act=%b%b exp=10", af_n, ae_n);
    end
    mrst_n = 1;
    repeat (4) @(posedge rclk);
  endtask

  task automatic shift_bits(input logic [2*PW-1:0] val, input int first, input int last, input bit noisy);
    for (int i = first; i >= last; i--) begin
      if (noisy && ($urandom % 3 == 0)) begin
        @(negedge wclk) begin ser_en = 0; ser_din = 1'($urandom); ld_en = 1'($urandom); ld_data = PW'($urandom); end
      end
      @(negedge wclk) begin ser_en = 1; ser_din = val[i]; ld_en = noisy ? 1'($urandom) : 1'b0; end
    end
    @(negedge wclk) begin ser_en = 0; ld_en = 0; end
  endtask

  task automatic par_load(input int v);
    @(negedge wclk) begin ld_en = 1; ld_data = PW'(v); end
    @(negedge wclk) ld_en = 0;
  endtask

  initial begin
    #(WPER * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int presets[5] = '{8, 16, 64, 256, 1024};
    void'($urandom(32'd4242));
    // R1 R2 R3 R8: every preset
    for (int s = 0; s < 5; s++) begin
      master_reset(3'(s));
      sweep(presets[s], presets[s], "R1", 6);
    end

    // R4 R6 R9: parallel mode
    master_reset(3'd5);
    shift_bits({12'd3, 12'd4}, 2*PW-1, 0, 0);   // R9 serial ignored
    sweep(8, 8, "R9", 2);
    par_load(100);
    chk_af(8, 8, "R6"); chk_af(9, 8, "R6");
    repeat (5) @(posedge rclk);
    chk_ae(8, 8, "R6"); chk_ae(9, 8, "R6");
    par_load(300);
    par_load(5);                                  // R4 extra strobe ignored
    repeat (5) @(posedge rclk);
    sweep(100, 300, "R4", 6);

    // R5 R6 R9: serial mode with gaps and stray strobes
    master_reset(3'd6);
    shift_bits({12'd37, 12'd1500}, 2*PW-1, PW, 1);
    chk_af(8, 8, "R6"); chk_af(9, 8, "R6");
    shift_bits({12'd37, 12'd1500}, PW-1, 0, 1);
    shift_bits({12'd5, 12'd6}, 2*PW-1, 0, 0);     // R5 bits after completion ignored
    repeat (5) @(posedge rclk);
    sweep(37, 1500, "R5", 6);

    // R7 partial reset keeps offsets
    @(negedge wclk) begin space_w = 0; words_r = 4000; prst_n = 0; end
    repeat (3) @(posedge rclk);
    @(negedge wclk);
    nchk++;
    if (af_n !== 1'b1) begin nfail++; $display("FAIL R7 af_n act=%b exp=1", af_n); end
    @(negedge rclk);
    nchk++;
    if (ae_n !== 1'b0) begin nfail++; $display("FAIL R7 ae_n act=%b exp=0", ae_n); end
    @(negedge wclk) prst_n = 1;
    sweep(37, 1500, "R7", 4);

    // R5 select 7 also serial, R8 new config on reset
    master_reset(3'd7);
    shift_bits({12'd2047, 12'd1}, 2*PW-1, 0, 1);
    repeat (5) @(posedge rclk);
    sweep(2047, 1, "R5", 4);
    master_reset(3'd1);
    par_load(900); par_load(900);                 // R9 ignored in preset mode
    sweep(16, 16, "R8", 4);

    finish_run();
  end
endmodule